// File: doc/BRIEF.md
# EEPROM Write-and-Poll Sequencer

This block sits on the host side of a byte-wide parallel EEPROM. A client hands it one command at a time over a valid/ready handshake. A command is either a byte read or a byte write, and carries a 13-bit address and an 8-bit data byte. The sequencer turns each command into chip-select, output-enable and write-strobe waveforms. Every timing limit of the memory is a parameter given in nanoseconds, and the block converts each one to a clock-cycle count from the configured clock period. The data bus is split into a driven half, an enable and a sampled half, so an FPGA pad can build the tristate.

After a write strobe, the memory runs its internal programming cycle, which lasts several milliseconds. The sequencer waits for that cycle to end in one of two ways, chosen per command:
- It watches the open-drain ready line and waits for it to return high.
- It reads the written address again and again until bit 7 reads back equal to the written bit 7. While the memory is still programming, that bit reads inverted.

A watchdog bounds either wait. When it expires, the command ends with a timeout flag. Each command ends with a single-cycle response that carries the read byte, or the written byte for writes, and the timeout flag.

Top module: `eeprom_seq`

## Requirements
- R1: After reset, and whenever the block is idle with `cmd_ready` high, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dq_oe` is low and `rsp_valid` is low.
- R2: A write (`cmd_write` = 1) produces exactly one low pulse on `mem_we_n`. The pulse lasts ceil(WP_NS/CLK_NS) cycles, which is 19 cycles at the defaults, and never more than WP_MAX_NS.
- R3: The write frame is set up and held around the strobe. `mem_ce_n` is low and `mem_oe_n` is high. The address and data are driven and stay stable from at least ceil(AS_NS/CLK_NS) cycles (2) before `mem_we_n` falls until at least ceil(DH_NS/CLK_NS) cycles (2) after it rises.
- R4: `mem_dq_oe` is never high while `mem_oe_n` is low. After `mem_oe_n` rises, `mem_dq_oe` stays low for at least ceil(DF_NS/CLK_NS) cycles (8).
- R5: A read (`cmd_write` = 0) holds `mem_oe_n` low for the larger of ceil(ACC_NS/CLK_NS) and ceil(OE_NS/CLK_NS) cycles (38) before it samples `mem_dq_in`. It then returns the byte stored at the address on `rsp_rdata`, with `rsp_valid` high for exactly one cycle and `rsp_timeout` low.
- R6: In ready-line mode (`cmd_poll` = 0), the write response comes only after `mem_rdy` (high = ready) has returned high, and within a few cycles of that. `mem_rdy` is ignored for ceil(DB_NS/CLK_NS) cycles after the strobe.
- R7: In polling mode (`cmd_poll` = 1), the block issues repeated full read cycles to the written address. It responds only after a sampled bit 7 equals bit 7 of the written byte. `rsp_rdata` carries the written byte.
- R8: If a write has not completed after ceil(TIMEOUT_NS/CLK_NS) cycles of waiting, the block responds with `rsp_timeout` = 1. `rsp_timeout` is never high without `rsp_valid`.
- R9: `cmd_ready` drops in the cycle after a command is accepted and stays low until the response cycle. No second command is taken while one is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_write | input | 1 | 1 = byte write, 0 = byte read |
| cmd_poll | input | 1 | End-of-write method: 1 = data-bit-7 polling, 0 = ready line |
| cmd_addr | input | 13 | Byte address |
| cmd_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_timeout | output | 1 | Write wait expired (valid with rsp_valid) |
| rsp_rdata | output | 8 | Read byte, or written byte for writes |
| mem_addr | output | 13 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Data read from the memory bus |
| mem_rdy | input | 1 | Open-drain ready line, high = ready |

## Verification
A wrong phase count in the sequencer shows first on the memory pins: a strobe of the wrong length, or a sample taken before the access window closes. A premature sample returns a stale or garbage byte on `rsp_rdata` in the same response. A state machine that leaves the wait states too early answers before the memory's write cycle has ended, and a read-back of the address then shows the old byte. A broken watchdog shows as a response arriving far too early, or never arriving. The bus-turnaround and strobe framing rules are also watched on every cycle, so a violation is reported on the cycle it happens.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,   // waiting for a command
    S_WSU,    // write: address/data/ce set up, strobe high
    S_WPL,    // write: strobe low
    S_WHD,    // write: strobe high, data held
    S_BDB,    // ready-line mode: blanking before the line is trusted
    S_BWT,    // ready-line mode: waiting for ready
    S_RSU,    // read: ce low, bus released, oe still high
    S_RACT,   // read: oe low, access window
    S_RFL     // read: oe high again, bus float window
  } seq_state_e;

  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/eeprom_seq_timer.sv
module eeprom_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (ld)         cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/eeprom_seq_wdog.sv
module eeprom_seq_wdog #(
  parameter int LIMIT = 1000,
  parameter int W     = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  logic [W-1:0] cnt;

  assign expired = (cnt >= W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eeprom_seq_sync.sv
module eeprom_seq_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= INIT;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= INIT;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_seq_pkg::*;
#(
  parameter int AW          = 13,
  parameter int DW          = 8,
  parameter int CLK_NS      = 8,
  parameter int AS_NS       = 10,
  parameter int AH_NS       = 100,
  parameter int WP_NS       = 150,
  parameter int WP_MAX_NS   = 1000,
  parameter int DS_NS       = 100,
  parameter int DH_NS       = 10,
  parameter int DB_NS       = 50,
  parameter int ACC_NS      = 300,
  parameter int OE_NS       = 150,
  parameter int DF_NS       = 60,
  parameter int TIMEOUT_NS  = 4000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic          cmd_poll,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic          rsp_timeout,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in,
  input  logic          mem_rdy
);
  // Phase lengths in cycles, all rounded up.
  localparam int WP_CYC = imin(ns2cyc(WP_NS, CLK_NS), WP_MAX_NS / CLK_NS);
  localparam int SU_CYC = imax(ns2cyc(AS_NS, CLK_NS), ns2cyc(DS_NS, CLK_NS) - WP_CYC);
  localparam int HD_CYC = imax(ns2cyc(DH_NS, CLK_NS), ns2cyc(AH_NS, CLK_NS) - WP_CYC);
  localparam int DB_CYC = ns2cyc(DB_NS, CLK_NS);
  localparam int RD_CYC = imax(ns2cyc(ACC_NS, CLK_NS), ns2cyc(OE_NS, CLK_NS));
  localparam int FL_CYC = ns2cyc(DF_NS, CLK_NS);
  localparam int TO_CYC = ns2cyc(TIMEOUT_NS, CLK_NS);
  localparam int CMAX   = imax(imax(imax(WP_CYC, SU_CYC), imax(HD_CYC, DB_CYC)),
                               imax(RD_CYC, FL_CYC));
  localparam int TW     = $clog2(CMAX + 1) + 1;
  localparam int WDW    = $clog2(TO_CYC + 1) + 1;

  seq_state_e    st_q, st_n;
  logic          tmr_ld, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          wd_clr, wd_run, wd_exp;
  logic          rdy_s;
  logic [DW-1:0] d_q, rd_q;
  logic          wr_q, poll_q, rdy_q;
  logic          fin, fin_to;

  assign cmd_ready = rdy_q;

  eeprom_seq_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .ld(tmr_ld), .ld_val(tmr_val), .done(tmr_done)
  );

  eeprom_seq_wdog #(.LIMIT(TO_CYC), .W(WDW)) u_wd (
    .clk(clk), .rst(rst), .clr(wd_clr), .run(wd_run), .expired(wd_exp)
  );

  eeprom_seq_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_rdy (
    .clk(clk), .rst(rst), .d(mem_rdy), .q(rdy_s)
  );

  // Next state and completion decision.
  always_comb begin
    st_n   = st_q;
    fin    = 1'b0;
    fin_to = 1'b0;
    case (st_q)
      S_IDLE: if (cmd_valid && rdy_q) st_n = cmd_write ? S_WSU : S_RSU;
      S_WSU:  if (tmr_done) st_n = S_WPL;
      S_WPL:  if (tmr_done) st_n = S_WHD;
      S_WHD:  if (tmr_done) st_n = poll_q ? S_RSU : S_BDB;
      S_BDB:  if (tmr_done) st_n = S_BWT;
      S_BWT: begin
        if (rdy_s) begin
          st_n = S_IDLE; fin = 1'b1;
        end else if (wd_exp) begin
          st_n = S_IDLE; fin = 1'b1; fin_to = 1'b1;
        end
      end
      S_RSU:  if (tmr_done) st_n = S_RACT;
      S_RACT: if (tmr_done) st_n = S_RFL;
      S_RFL: begin
        if (tmr_done) begin
          if (!wr_q || (rd_q[DW-1] == d_q[DW-1])) begin
            st_n = S_IDLE; fin = 1'b1;
          end else if (wd_exp) begin
            st_n = S_IDLE; fin = 1'b1; fin_to = 1'b1;
          end else begin
            st_n = S_RSU;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  // Phase timer reloads on every state change with the new phase length - 1.
  assign tmr_ld = (st_n != st_q);
  always_comb begin
    case (st_n)
      S_WSU:   tmr_val = TW'(SU_CYC - 1);
      S_WPL:   tmr_val = TW'(WP_CYC - 1);
      S_WHD:   tmr_val = TW'(HD_CYC - 1);
      S_BDB:   tmr_val = TW'(DB_CYC - 1);
      S_RACT:  tmr_val = TW'(RD_CYC - 1);
      S_RFL:   tmr_val = TW'(FL_CYC - 1);
      default: tmr_val = '0;
    endcase
  end

  // Watchdog covers everything after the strobe of a write.
  assign wd_clr = (st_q == S_IDLE);
  assign wd_run = wr_q && (st_q inside {S_BDB, S_BWT, S_RSU, S_RACT, S_RFL});

  // Registered bus and response outputs, updated on state entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= S_IDLE;
      rdy_q       <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_timeout <= 1'b0;
      rsp_rdata   <= '0;
      mem_addr    <= '0;
      mem_ce_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_dq_out  <= '0;
      mem_dq_oe   <= 1'b0;
      d_q         <= '0;
      rd_q        <= '0;
      wr_q        <= 1'b0;
      poll_q      <= 1'b0;
    end else begin
      st_q        <= st_n;
      rsp_valid   <= fin;
      rsp_timeout <= fin & fin_to;
      if (fin) begin
        rsp_rdata <= wr_q ? d_q : rd_q;
        rdy_q     <= 1'b1;
        mem_ce_n  <= 1'b1;
        mem_oe_n  <= 1'b1;
        mem_we_n  <= 1'b1;
        mem_dq_oe <= 1'b0;
      end
      if (st_n != st_q) begin
        case (st_n)
          S_WSU: begin
            mem_addr   <= cmd_addr;
            mem_dq_out <= cmd_wdata;
            mem_dq_oe  <= 1'b1;
            mem_ce_n   <= 1'b0;
            d_q        <= cmd_wdata;
            wr_q       <= 1'b1;
            poll_q     <= cmd_poll;
            rdy_q      <= 1'b0;
          end
          S_WPL: mem_we_n <= 1'b0;
          S_WHD: mem_we_n <= 1'b1;
          S_BDB: begin
            mem_ce_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
          end
          S_RSU: begin
            if (st_q == S_IDLE) begin
              mem_addr <= cmd_addr;
              wr_q     <= 1'b0;
              rdy_q    <= 1'b0;
            end
            mem_ce_n  <= 1'b0;
            mem_dq_oe <= 1'b0;
            mem_oe_n  <= 1'b1;
          end
          S_RACT: mem_oe_n <= 1'b0;
          S_RFL: begin
            mem_oe_n <= 1'b1;
            mem_ce_n <= 1'b1;
            rd_q     <= mem_dq_in;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_seq_chk.sv
module eeprom_seq_chk #(
  parameter int AW        = 13,
  parameter int DW        = 8,
  parameter int CLK_NS    = 8,
  parameter int WP_MAX_NS = 1000,
  parameter int DF_NS     = 60
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rsp_valid,
  input logic          rsp_timeout,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe
);
  localparam int WP_MAX_CYC = WP_MAX_NS / CLK_NS;
  localparam int FL_CYC     = (DF_NS + CLK_NS - 1) / CLK_NS;

  logic [15:0] we_cnt;
  logic [15:0] fl_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_cnt <= '0;
      fl_cnt <= 16'(FL_CYC);
    end else begin
      we_cnt <= mem_we_n ? '0 : we_cnt + 1'b1;
      if (!mem_oe_n)                fl_cnt <= '0;
      else if (fl_cnt < 16'(FL_CYC)) fl_cnt <= fl_cnt + 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (mem_we_n && mem_oe_n && mem_ce_n && !mem_dq_oe));

  assert_pulse_max_R2: assert property (@(posedge clk) disable iff (rst)
    we_cnt <= 16'(WP_MAX_CYC));

  assert_we_frame_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n));

  assert_we_stable_R3: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_no_contention_R4: assert property (@(posedge clk) disable iff (rst)
    !(mem_dq_oe && !mem_oe_n));

  assert_float_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (fl_cnt < 16'(FL_CYC)) |-> !mem_dq_oe);

  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_timeout_flag_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_timeout |-> rsp_valid);

  assert_accept_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
endmodule

bind eeprom_seq eeprom_seq_chk #(
  .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .WP_MAX_NS(WP_MAX_NS), .DF_NS(DF_NS)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout), .mem_addr(mem_addr),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_eeprom_seq.sv
module sim_eeprom_seq;
  localparam int TO_NS  = 40000;
  localparam int TO_CYC = 5000;  // TO_NS / 8
  localparam int BUSY   = 600;   // model write-cycle length in cycles
  localparam int ACC_NEG = 38;   // negedges of oe low before model data is valid (300 ns)

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_poll = 1'b0;
  logic [12:0] cmd_addr = '0;
  logic [7:0]  cmd_wdata = '0;
  logic        cmd_ready, rsp_valid, rsp_timeout;
  logic [7:0]  rsp_rdata;
  logic [12:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'h00;
  logic        mem_rdy = 1'b1;

  eeprom_seq #(.CLK_NS(8), .TIMEOUT_NS(TO_NS)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_poll(cmd_poll), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_timeout(rsp_timeout),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in), .mem_rdy(mem_rdy)
  );

  int checks = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model and pin monitors (negedge) ----------------
  logic [7:0] bmem [64];
  bit         stuck = 0, bsy = 0;
  bit         poke_en = 0;
  logic [5:0] poke_a = '0;
  logic [7:0] poke_d = '0;
  int         bcnt = 0, done_cyc = 0, rise_cyc = 0, oe_neg = 0, oe_starts = 0;
  logic [5:0] wa = '0;
  logic [7:0] wd = '0;
  bit         pwe = 1, poe = 1, pdq = 0, hold_track = 0;
  int         we_lo = 0, su = 0, hd = 0, fl = 100;
  logic [12:0] pa = '0;
  bit         frame_bad = 0, cont_bad = 0;

  always @(negedge clk) begin
    if (poke_en) bmem[poke_a] <= poke_d;
    // setup and hold tracking around the strobe
    if (mem_dq_oe && mem_we_n && !hold_track) su++;
    else if (!mem_dq_oe) su = 0;
    if (hold_track) begin
      if (mem_dq_oe) hd++;
      else begin
        chk(hd >= 2, "R3", "data hold cycles after strobe", hd, 2);
        hold_track = 0;
      end
    end
    if (pwe && !mem_we_n) begin
      wa = mem_addr[5:0];
      chk(su >= 2, "R3", "setup cycles before strobe", su, 2);
    end
    if (!mem_we_n) begin
      we_lo++;
      if (!(mem_oe_n && mem_dq_oe && !mem_ce_n) || mem_addr != pa) frame_bad = 1;
    end
    if (!pwe && mem_we_n) begin
      chk(we_lo == 19, "R2", "strobe width cycles", we_lo, 19);
      we_lo = 0;
      wd = mem_dq_out;
      bsy = 1; bcnt = BUSY; mem_rdy <= 1'b0;
      rise_cyc = cyc; oe_starts = 0;
      hold_track = 1; hd = 1;
    end else if (bsy && !stuck) begin
      bcnt--;
      if (bcnt == 0) begin
        bmem[wa] <= wd; bsy = 0; mem_rdy <= 1'b1; done_cyc = cyc;
      end
    end
    // bus turnaround
    if (mem_dq_oe && !mem_oe_n) cont_bad = 1;
    if (!pdq && mem_dq_oe) chk(fl >= 8, "R4", "float cycles before drive", fl, 8);
    if (!mem_oe_n) fl = 0; else if (fl < 100) fl++;
    // read data
    if (!mem_ce_n && !mem_oe_n) begin
      if (poe) oe_starts++;
      oe_neg++;
      if (oe_neg >= ACC_NEG)
        mem_dq_in <= (bsy && mem_addr[5:0] == wa) ? {~wd[7], wd[6:0] ^ 7'h2A}
                                                  : bmem[mem_addr[5:0]];
      else
        mem_dq_in <= 8'hEE;
    end else begin
      oe_neg = 0;
      mem_dq_in <= 8'h00;
    end
    pwe = mem_we_n; poe = mem_oe_n; pdq = mem_dq_oe; pa = mem_addr;
  end

  // ---------------- command driver ----------------
  logic [7:0] r_data;
  logic       r_to;
  int         r_cyc;

  task automatic poke(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); poke_en = 1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic do_cmd(input bit wr, input bit pl, input logic [12:0] a,
                        input logic [7:0] d);
    bit got = 0, ready_bad = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_write = wr; cmd_poll = pl; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
    for (int n = 0; n < 20000 && !got; n++) begin
      if (rsp_valid) got = 1;
      else begin
        if (cmd_ready) ready_bad = 1;
        @(negedge clk);
      end
    end
    r_data = rsp_rdata; r_to = rsp_timeout; r_cyc = cyc;
    chk(got, "R9", "response arrived", int'(got), 1);
    chk(!ready_bad, "R9", "ready low while in flight", int'(ready_bad), 0);
    @(negedge clk);
    chk(!rsp_valid, "R5", "response is one cycle", int'(rsp_valid), 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(cmd_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
        "R1", "idle pins after reset",
        {cmd_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid}, 6'b111100);
  endtask

  task automatic t_read(input logic [5:0] a, input logic [7:0] v);
    poke(a, v);
    do_cmd(0, 0, {7'd0, a}, 8'h00);
    chk(r_data == v, "R5", "read byte", r_data, v);
    chk(!r_to, "R5", "read timeout flag", r_to, 0);
  endtask

  task automatic t_write_line(input logic [5:0] a, input logic [7:0] v);
    frame_bad = 0;
    do_cmd(1, 0, {7'd0, a}, v);
    chk(!frame_bad, "R3", "frame during strobe", frame_bad, 0);
    chk(!r_to && r_data == v, "R6", "ready-line response", {r_to, r_data}, {1'b0, v});
    chk(r_cyc >= done_cyc && r_cyc <= done_cyc + 8, "R6",
        "response after ready returns", r_cyc - done_cyc, 4);
    t_read(a, v);  // read-back must return new byte (model pokes same value)
  endtask

  task automatic t_write_poll(input logic [5:0] a, input logic [7:0] v);
    frame_bad = 0;
    do_cmd(1, 1, {7'd0, a}, v);
    chk(!frame_bad, "R3", "frame during strobe", frame_bad, 0);
    chk(!r_to && r_data == v, "R7", "polling response", {r_to, r_data}, {1'b0, v});
    chk(r_cyc >= done_cyc && r_cyc <= done_cyc + 100, "R7",
        "response after bit 7 settles", r_cyc - done_cyc, 50);
    chk(oe_starts >= 2, "R7", "repeated poll reads", oe_starts, 2);
    do_cmd(0, 0, {7'd0, a}, 8'h00);
    chk(r_data == v, "R7", "byte stored after polling write", r_data, v);
  endtask

  task automatic t_timeout(input bit pl, input logic [5:0] a, input logic [7:0] v);
    int el;
    stuck = 1;
    do_cmd(1, pl, {7'd0, a}, v);
    el = r_cyc - rise_cyc;
    chk(r_to == 1'b1, "R8", "timeout flag", r_to, 1);
    chk(el >= TO_CYC && el <= TO_CYC + (pl ? 70 : 10), "R8",
        "wait length before timeout", el, TO_CYC);
    stuck = 0;
    repeat (BUSY + 20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read(6'd5, 8'h3C);
    t_read(6'd9, 8'hC3);
    t_write_line(6'd12, 8'h9A);
    t_write_line(6'd13, 8'h05);
    t_write_poll(6'd20, 8'h81);
    t_write_poll(6'd21, 8'h17);
    t_timeout(0, 6'd30, 8'h44);
    t_timeout(1, 6'd31, 8'hB2);
    t_read(6'd40, 8'h00);
    chk(!cont_bad, "R4", "no drive while oe low", cont_bad, 0);
    @(negedge clk);
    chk(cmd_ready && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "idle pins at end",
        {cmd_ready, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule